// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the timing strobes for a PCM audio serial port. A 16-bit configuration word chooses one of two timing sources and sets two cascaded divide-by-(N+1) stages. The first stage divides the chosen source down to the bit rate. The second stage counts bit periods to mark the start of each frame. All logic runs on one core clock. Each timing source reaches the block as a single-cycle tick in that clock domain, so the block derives no clocks.

The outputs are a one-cycle bit strobe, a one-cycle frame-start strobe that coincides with the bit strobe that opens a frame, and a readback of the configuration word. The frame stage counts all the time, so its timing stays valid when the serial port takes its frame sync from outside. After reset every field is zero. In that state every selected tick is a bit period, and every bit period is a whole frame.

Top module: `acg_clockgen`

## Requirements
- R1: A write (wrEn high at a clock edge) stores all 16 bits of wrData. rdData shows the stored word from the cycle after the edge and holds it until the next write.
- R2: While rstN is low, rdData is zero and both strobes are low. With the all-zero word after reset, every selected tick yields a bit strobe together with a frame sync.
- R3: Bit 0 of the word selects the timing source: 0 selects auxTick and 1 selects fastTick. Ticks on the source that is not selected have no effect on either strobe.
- R4: Bits 15:8 hold the bit divider N. bitStrobe pulses for one cycle, in the cycle after every (N+1)-th selected tick, counting from the first tick after reset.
- R5: Bits 7:1 hold the frame divider F, with F up to 127. frameSync pulses together with every (F+1)-th bit strobe, starting with the first bit strobe after reset, which allows up to 128 bit periods per frame.
- R6: A changed divider value takes effect only when its stage next reloads. The period that is running completes with its old length.
- R7: frameSync is never high unless bitStrobe is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write enable |
| wrData | input | 16 | Configuration word to store |
| auxTick | input | 1 | Tick from timing source 0 |
| fastTick | input | 1 | Tick from timing source 1 |
| rdData | output | 16 | Stored configuration word |
| bitStrobe | output | 1 | One-cycle bit period strobe |
| frameSync | output | 1 | One-cycle frame start strobe |

## Verification
The bench builds the block with its default widths: an 8-bit bit divider and a 7-bit frame divider. With these widths, the largest bit period (256 ticks) and the longest frame (128 bit periods) both fit into short runs. The frame case runs with a bit divider of zero, so the frame wrap at 128 is reached within a few hundred cycles. Irregular tick patterns from a shift-register sequence exercise the divider counts. Writes made in the middle of a period show that a new value waits for the next reload.

// File: rtl/acg_pkg.sv
package acg_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic srcTick;  // tick of the currently selected timing source
  } acg_strb_t;
endpackage

// File: rtl/acg_prescaler.sv
// Down-counter that reloads on terminal count; wrap marks each (N+1)-th step.
module acg_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  input  logic [W-1:0] reloadVal,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (step)  cnt <= wrap ? reloadVal : cnt - 1'b1;
  end
endmodule

// File: rtl/acg_ctrl.sv
// Configuration word and timing source selection.
module acg_ctrl
  import acg_pkg::*;
#(
  parameter int BIT_W = 8,
  parameter int FRM_W = 7,
  localparam int REG_W = 1 + FRM_W + BIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             auxTick,
  input  logic             fastTick,
  output acg_strb_t        strb,
  output logic [BIT_W-1:0] bitDiv,
  output logic [FRM_W-1:0] frmDiv,
  output logic [REG_W-1:0] rdData
);
  localparam int SEL_POS = 0;
  localparam int FRM_LO  = 1;
  localparam int BIT_LO  = 1 + FRM_W;

  logic [REG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgQ <= '0;
    else if (wrEn) cfgQ <= wrData;
  end

  assign bitDiv       = cfgQ[BIT_LO +: BIT_W];
  assign frmDiv       = cfgQ[FRM_LO +: FRM_W];
  assign strb.srcTick = cfgQ[SEL_POS] ? fastTick : auxTick;
  assign rdData       = cfgQ;
endmodule

// File: rtl/acg_datapath.sv
// Two cascaded prescaler stages with registered strobe outputs.
module acg_datapath
  import acg_pkg::*;
#(
  parameter int BIT_W = 8,
  parameter int FRM_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  acg_strb_t        strb,
  input  logic [BIT_W-1:0] bitDiv,
  input  logic [FRM_W-1:0] frmDiv,
  output logic             bitStrobe,
  output logic             frameSync
);
  logic bitWrap;
  logic frmWrap;

  acg_prescaler #(.W(BIT_W)) u_bitStage (
    .clk(clk), .rstN(rstN), .step(strb.srcTick),
    .reloadVal(bitDiv), .wrap(bitWrap)
  );

  acg_prescaler #(.W(FRM_W)) u_frmStage (
    .clk(clk), .rstN(rstN), .step(bitWrap),
    .reloadVal(frmDiv), .wrap(frmWrap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitStrobe <= 1'b0;
      frameSync <= 1'b0;
    end else begin
      bitStrobe <= bitWrap;
      frameSync <= frmWrap;
    end
  end
endmodule

// File: rtl/acg_clockgen.sv
module acg_clockgen
  import acg_pkg::*;
#(
  parameter int BIT_W = 8,
  parameter int FRM_W = 7,
  localparam int REG_W = 1 + FRM_W + BIT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             auxTick,
  input  logic             fastTick,
  output logic [REG_W-1:0] rdData,
  output logic             bitStrobe,
  output logic             frameSync
);
  acg_strb_t        strb;
  logic [BIT_W-1:0] bitDiv;
  logic [FRM_W-1:0] frmDiv;

  acg_ctrl #(.BIT_W(BIT_W), .FRM_W(FRM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .auxTick(auxTick), .fastTick(fastTick), .strb(strb),
    .bitDiv(bitDiv), .frmDiv(frmDiv), .rdData(rdData)
  );

  acg_datapath #(.BIT_W(BIT_W), .FRM_W(FRM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitDiv(bitDiv),
    .frmDiv(frmDiv), .bitStrobe(bitStrobe), .frameSync(frameSync)
  );
endmodule

// File: rtl/acg_clockgen_chk.sv
module acg_clockgen_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             auxTick,
  input logic             fastTick,
  input logic [REG_W-1:0] rdData,
  input logic             bitStrobe,
  input logic             frameSync
);
  // R1: a write appears on the readback one cycle later
  a_r1_write_seen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn)) |-> (rdData == $past(wrData)));

  // R1: without a write the readback holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn)) |-> $stable(rdData));

  // R2: reset clears the word and silences the strobes
  a_r2_reset_clear: assert property (@(posedge clk)
    !rstN |=> (rdData == '0 && !bitStrobe && !frameSync));

  // R3: a bit strobe follows a tick on the source selected at that time
  a_r3_src_only: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> $past(rdData[0] ? fastTick : auxTick));

  // R7: frame sync only together with a bit strobe
  a_r7_frame_in_bit: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> bitStrobe);
endmodule

bind acg_clockgen acg_clockgen_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .auxTick(auxTick), .fastTick(fastTick), .rdData(rdData),
  .bitStrobe(bitStrobe), .frameSync(frameSync)
);

// File: tb/acg_clockgen_bench.sv
`timescale 1ns/1ps
module acg_clockgen_bench;
  localparam int REG_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [REG_W-1:0] wrData = '0;
  logic             auxTick = 1'b0;
  logic             fastTick = 1'b0;
  logic [REG_W-1:0] rdData;
  logic             bitStrobe;
  logic             frameSync;

  always #5 clk = ~clk;

  acg_clockgen u_acg_clockgen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .auxTick(auxTick), .fastTick(fastTick), .rdData(rdData),
    .bitStrobe(bitStrobe), .frameSync(frameSync)
  );

  typedef struct {
    logic             expBit;
    logic             expFrm;
    logic [REG_W-1:0] expRd;
    string            tag;
  } item_t;

  item_t expQ[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 0;

  // reference state built from the requirements
  logic [REG_W-1:0] mReg = '0;
  int               mBitLeft = 0;
  int               mFrmLeft = 0;
  logic [15:0]      lfsr = 16'hACE1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic drive(bit wr, logic [REG_W-1:0] data, bit aux, bit fast, string tag);
    item_t it;
    bit    tick;
    @(negedge clk);
    wrEn = wr; wrData = data; auxTick = aux; fastTick = fast;
    tick = mReg[0] ? fast : aux;
    it.expBit = tick && (mBitLeft == 0);
    it.expFrm = it.expBit && (mFrmLeft == 0);
    if (tick)      mBitLeft = (mBitLeft == 0) ? int'(mReg[15:8]) : mBitLeft - 1;
    if (it.expBit) mFrmLeft = (mFrmLeft == 0) ? int'(mReg[7:1]) : mFrmLeft - 1;
    if (wr) mReg = data;
    it.expRd = mReg;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  function automatic bit pick(int mode);
    if (mode == 1) return 1'b1;
    if (mode == 2) return lfsr[0];
    return 1'b0;
  endfunction

  task automatic run(int n, int auxMode, int fastMode, string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(1'b0, '0, pick(auxMode), pick(fastMode), tag);
    end
  endtask

  task automatic wr(logic [REG_W-1:0] data, string tag);
    drive(1'b1, data, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares outputs after each edge with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(bitStrobe === it.expBit, it.tag, "bitStrobe", bitStrobe, it.expBit);
        check(frameSync === it.expFrm, it.tag, "frameSync", frameSync, it.expFrm);
        check(rdData === it.expRd, "R1", "rdData", rdData, it.expRd);
        check(!(frameSync && !bitStrobe), "R7", "frame without bit", frameSync, 0);
      end
    end
  end

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2: reset state with ticks present
    auxTick = 1'b1; wrEn = 1'b1; wrData = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(rdData === '0, "R2", "reset rdData", rdData, 0);
    check(bitStrobe === 1'b0, "R2", "reset bitStrobe", bitStrobe, 0);
    check(frameSync === 1'b0, "R2", "reset frameSync", frameSync, 0);
    wrEn = 1'b0; wrData = '0; auxTick = 1'b0;
    rstN = 1'b1;

    // R2: zero dividers, each tick is a bit and a frame
    run(6, 1, 0, "R2");
    run(10, 2, 0, "R2");

    // R3: unselected source ignored, then switch to the fast source
    run(12, 0, 1, "R3");
    wr(16'h0001, "R3");
    run(12, 1, 0, "R3");
    run(20, 0, 2, "R3");
    wr(16'h0000, "R3");
    run(8, 0, 1, "R3");

    // R4: bit divider 3 with irregular ticks, then the maximum 255
    wr(16'h0300, "R4");
    run(60, 2, 1, "R4");
    wr(16'hFF00, "R4");
    run(700, 1, 0, "R4");

    // R5: frame divider 127 at full tick rate, then bit 2 / frame 5
    wr(16'h00FE, "R5");
    run(300, 1, 0, "R5");
    wr(16'h020A, "R5");
    run(150, 2, 0, "R5");

    // R6: change dividers in the middle of a running period
    wr(16'h0A00, "R6");
    run(15, 1, 0, "R6");
    wr(16'h0106, "R6");
    run(30, 1, 0, "R6");
    wr(16'h0000, "R6");
    run(20, 1, 0, "R6");

    // R1: write patterns and readback
    wr(16'hA5C3, "R1");
    run(3, 2, 2, "R1");
    wr(16'h5A3C, "R1");
    run(3, 2, 2, "R1");
    drive(1'b1, 16'hFFFF, 1'b1, 1'b1, "R1");
    drive(1'b1, 16'h0000, 1'b1, 1'b1, "R1");
    run(4, 1, 1, "R1");

    @(negedge clk);
    wrEn = 1'b0; auxTick = 1'b0; fastTick = 1'b0;
    @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule